// File: doc/BRIEF.md
# Unaligned Access Bus Splitter

This block connects a processor load/store port to a memory bus that only carries naturally aligned full-width words. The processor hands over one access of byte, halfword or word size at any byte address. The block turns that access into the aligned bus traffic it needs. An access whose bytes all fall inside one bus word becomes a single beat. An access that crosses a word boundary becomes two beats in a row, at consecutive word addresses, each with only the needed byte lanes enabled.

On writes the block moves each byte of the processor data onto its lane. On reads it collects the requested bytes from one or both returned beats and hands back a single right-justified value. With the response the block reports whether the access reached memory as one indivisible beat, which means it was single-copy atomic, or whether it was broken up. The processor port takes no new request until the response of the current one has been given.

Top module: `uas_splitter`

## Requirements
- R1: `req_size_i` encodes 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word. An access whose bytes all lie in one bus word produces exactly one beat. Its address has the low two bits cleared. `bus_strb_o` bit i is set exactly for each lane i the access touches, where lane i is byte address offset i and carries data bits [8i+7:8i].
- R2: An access that crosses a word boundary produces exactly two beats. The first is at the word base and strobes the lanes from the start offset up to lane 3. The second is at base+4 and strobes lanes 0 upward for the remaining bytes. Examples: a word at offset 2 gives strobes 1100 then 0011; a halfword at offset 3 gives 1000 then 0001.
- R3: Write data is little-endian. Processor byte k goes on the lane of byte address addr+k within its beat. All non-strobed lanes, and all lanes of read beats, are driven with zero.
- R4: A read response returns byte k of the access, taken from address addr+k, in `rsp_rdata_o[8k+7:8k]`. All bits above the access size are zero.
- R5: `rsp_valid_o` is high for exactly one cycle, in the cycle after the final beat's handshake (`bus_valid_o` and `bus_ready_i` both high). `rsp_atomic_o` is 1 for a single-beat access and 0 for a split one.
- R6: `req_ready_o` is high only when no access is in progress. A request is taken on `req_valid_i` and `req_ready_o` both high. No request is taken during any beat or during the response cycle. The first beat is presented in the cycle after acceptance. For a split access, the second beat follows directly after the first beat's handshake.
- R7: While `bus_valid_o` is high and `bus_ready_i` is low, the beat stays presented with unchanged address, strobes, direction and write data.
- R8: `rsp_rdata_o` is zero in the response to a write.
- R9: During reset, `req_ready_o` is high and `bus_valid_o` and `rsp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present |
| req_ready_o | output | 1 | Block can take a request |
| req_addr_i | input | AW | Byte address of the access |
| req_size_i | input | 2 | Access size code |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DW | Right-justified write data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DW | Right-justified, zero-extended read result |
| rsp_atomic_o | output | 1 | Access was done as one beat |
| bus_valid_o | output | 1 | Beat presented |
| bus_ready_i | input | 1 | Memory accepts the beat |
| bus_addr_o | output | AW | Word-aligned beat address |
| bus_write_o | output | 1 | Beat direction |
| bus_strb_o | output | DW/8 | Byte-lane enables |
| bus_wdata_o | output | DW | Lane-steered write data |
| bus_rdata_i | input | DW | Read data, valid in the handshake cycle |

## Verification
The bound checker watches, on every cycle, the properties that hold beat by beat. Beat addresses must be aligned with at least one strobe set. The second beat must sit one word above the first. A split must never grow past two beats. A stalled beat must stay frozen. Request acceptance must stay closed while a beat or response is outstanding. The response pulse must last one cycle, and its atomic flag must match the beat count. Whether the strobes pick exactly the right lanes, whether write bytes land on the right lanes, and whether read bytes are merged in the right order from both beats can only be shown by the bench. The bench compares these against a byte-addressed model of memory, using directed boundary offsets, an address that wraps the modelled space, and randomly stalled traffic.

// File: rtl/uas_pkg.sv
package uas_pkg;
  localparam int unsigned SIZE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT0 = 2'd1,
    ST_BEAT1 = 2'd2,
    ST_RESP  = 2'd3
  } uas_state_e;

  // byte count of a size code, clipped to the bus width
  function automatic int size_bytes(input logic [SIZE_W-1:0] sz, input int nb);
    int b;
    b = 1 << sz;
    return (b > nb) ? nb : b;
  endfunction
endpackage

// File: rtl/uas_lane_plan.sv
module uas_lane_plan
  import uas_pkg::*;
#(
  parameter int NB = 4,
  parameter int OW = 2
) (
  input  logic [OW-1:0]     off_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [8*NB-1:0]   wdata_i,
  output logic [NB-1:0]     strb_lo_o,
  output logic [NB-1:0]     strb_hi_o,
  output logic              split_o,
  output logic [8*NB-1:0]   wdata_lo_o,
  output logic [8*NB-1:0]   wdata_hi_o
);
  logic [2*NB-1:0]   mask;
  logic [16*NB-1:0]  wide;
  int                n;

  // lane map over two adjacent words
  always_comb begin
    n    = size_bytes(size_i, NB);
    mask = '0;
    wide = '0;
    for (int k = 0; k < NB; k++) begin
      if (k < n) begin
        mask[int'(off_i) + k]          = 1'b1;
        wide[8*(int'(off_i) + k) +: 8] = wdata_i[8*k +: 8];
      end
    end
  end

  assign strb_lo_o  = mask[NB-1:0];
  assign strb_hi_o  = mask[2*NB-1:NB];
  assign split_o    = |mask[2*NB-1:NB];
  assign wdata_lo_o = wide[8*NB-1:0];
  assign wdata_hi_o = wide[16*NB-1:8*NB];
endmodule

// File: rtl/uas_rd_merge.sv
module uas_rd_merge
  import uas_pkg::*;
#(
  parameter int NB = 4,
  parameter int OW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic [8*NB-1:0]   rdata_i,
  input  logic [OW-1:0]     off_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              en_i,
  output logic [8*NB-1:0]   rdata_o
);
  logic [8*NB-1:0] lo_q, hi_q;
  logic [16*NB-1:0] pair;
  int nb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo_i) lo_q <= rdata_i;
      if (cap_hi_i) hi_q <= rdata_i;
    end
  end

  assign pair = {hi_q, lo_q};
  always_comb nb = size_bytes(size_i, NB);

  for (genvar j = 0; j < NB; j++) begin : g_byte
    logic [7:0] pick;
    always_comb pick = pair[8*(int'(off_i) + j) +: 8];
    assign rdata_o[8*j +: 8] = (en_i && (j < nb)) ? pick : 8'h00;
  end
endmodule

// File: rtl/uas_ctrl.sv
module uas_ctrl
  import uas_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic split_i,
  input  logic bus_ready_i,
  output logic req_ready_o,
  output logic req_fire_o,
  output logic bus_valid_o,
  output logic hi_beat_o,
  output logic cap_lo_o,
  output logic cap_hi_o,
  output logic rsp_valid_o
);
  uas_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_BEAT0;
      ST_BEAT0: if (bus_ready_i) state_d = split_i ? ST_BEAT1 : ST_RESP;
      ST_BEAT1: if (bus_ready_i) state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign req_fire_o  = req_ready_o && req_valid_i;
  assign bus_valid_o = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
  assign hi_beat_o   = (state_q == ST_BEAT1);
  assign cap_lo_o    = (state_q == ST_BEAT0) && bus_ready_i;
  assign cap_hi_o    = (state_q == ST_BEAT1) && bus_ready_i;
  assign rsp_valid_o = (state_q == ST_RESP);
endmodule

// File: rtl/uas_splitter.sv
module uas_splitter
  import uas_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic              req_write_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic              rsp_atomic_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic [AW-1:0]     bus_addr_o,
  output logic              bus_write_o,
  output logic [DW/8-1:0]   bus_strb_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic [DW-1:0]     bus_rdata_i
);
  localparam int NB = DW / 8;
  localparam int OW = $clog2(NB);

  logic [AW-1:0]     addr_q;
  logic [SIZE_W-1:0] size_q;
  logic              write_q;
  logic [DW-1:0]     wdata_q;

  logic req_fire, hi_beat, cap_lo, cap_hi, split;
  logic [NB-1:0] strb_lo, strb_hi;
  logic [DW-1:0] wdata_lo, wdata_hi;
  logic [AW-OW-1:0] word_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (req_fire) begin
      addr_q  <= req_addr_i;
      size_q  <= req_size_i;
      write_q <= req_write_i;
      wdata_q <= req_wdata_i;
    end
  end

  uas_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .split_i     (split),
    .bus_ready_i (bus_ready_i),
    .req_ready_o (req_ready_o),
    .req_fire_o  (req_fire),
    .bus_valid_o (bus_valid_o),
    .hi_beat_o   (hi_beat),
    .cap_lo_o    (cap_lo),
    .cap_hi_o    (cap_hi),
    .rsp_valid_o (rsp_valid_o)
  );

  uas_lane_plan #(.NB(NB), .OW(OW)) u_plan (
    .off_i      (addr_q[OW-1:0]),
    .size_i     (size_q),
    .wdata_i    (wdata_q),
    .strb_lo_o  (strb_lo),
    .strb_hi_o  (strb_hi),
    .split_o    (split),
    .wdata_lo_o (wdata_lo),
    .wdata_hi_o (wdata_hi)
  );

  uas_rd_merge #(.NB(NB), .OW(OW)) u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_lo_i (cap_lo),
    .cap_hi_i (cap_hi),
    .rdata_i  (bus_rdata_i),
    .off_i    (addr_q[OW-1:0]),
    .size_i   (size_q),
    .en_i     (rsp_valid_o && !write_q),
    .rdata_o  (rsp_rdata_o)
  );

  assign word_sel     = addr_q[AW-1:OW] + {{(AW-OW-1){1'b0}}, hi_beat};
  assign bus_addr_o   = {word_sel, {OW{1'b0}}};
  assign bus_write_o  = write_q;
  assign bus_strb_o   = hi_beat ? strb_hi : strb_lo;
  assign bus_wdata_o  = !write_q ? '0 : (hi_beat ? wdata_hi : wdata_lo);
  assign rsp_atomic_o = rsp_valid_o && !split;
endmodule

// File: rtl/uas_splitter_chk.sv
module uas_splitter_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            rsp_valid_o,
  input logic [DW-1:0]   rsp_rdata_o,
  input logic            rsp_atomic_o,
  input logic            bus_valid_o,
  input logic            bus_ready_i,
  input logic [AW-1:0]   bus_addr_o,
  input logic            bus_write_o,
  input logic [DW/8-1:0] bus_strb_o,
  input logic [DW-1:0]   bus_wdata_o
);
  localparam int NB = DW / 8;
  localparam int OW = $clog2(NB);

  logic [1:0]    beats_q;
  logic [AW-1:0] first_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beats_q      <= '0;
      first_addr_q <= '0;
    end else if (req_valid_i && req_ready_o) begin
      beats_q <= '0;
    end else if (bus_valid_o && bus_ready_i) begin
      beats_q <= beats_q + 2'd1;
      if (beats_q == 2'd0) first_addr_q <= bus_addr_o;
    end
  end

  // R1
  addr_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> bus_addr_o[OW-1:0] == '0);
  // R1
  strb_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> bus_strb_o != '0);
  // R2
  second_beat_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && beats_q == 2'd1) |-> (bus_addr_o == first_addr_q + AW'(NB)) && bus_strb_o[0]);
  // R2
  max_two_beats_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> beats_q < 2'd2);
  // R5
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R5
  atomic_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_atomic_o == (beats_q == 2'd1));
  // R6
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o || rsp_valid_o) |-> !req_ready_o);
  // R7
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=> bus_valid_o && $stable(bus_addr_o) && $stable(bus_strb_o)
      && $stable(bus_write_o) && $stable(bus_wdata_o));
  // R8
  write_rsp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && bus_write_o) |-> rsp_rdata_o == '0);
endmodule

bind uas_splitter uas_splitter_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_rdata_o  (rsp_rdata_o),
  .rsp_atomic_o (rsp_atomic_o),
  .bus_valid_o  (bus_valid_o),
  .bus_ready_i  (bus_ready_i),
  .bus_addr_o   (bus_addr_o),
  .bus_write_o  (bus_write_o),
  .bus_strb_o   (bus_strb_o),
  .bus_wdata_o  (bus_wdata_o)
);

// File: tb/uas_splitter_tb.sv
`timescale 1ns/1ps
module uas_splitter_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic        rsp_atomic_o;
  logic        bus_valid_o;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_addr_o;
  logic        bus_write_o;
  logic [3:0]  bus_strb_o;
  logic [31:0] bus_wdata_o;
  logic [31:0] bus_rdata = '0;

  always #2 clk = ~clk;

  uas_splitter u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_write_i(req_write), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .rsp_atomic_o(rsp_atomic_o),
    .bus_valid_o(bus_valid_o), .bus_ready_i(bus_ready), .bus_addr_o(bus_addr_o),
    .bus_write_o(bus_write_o), .bus_strb_o(bus_strb_o), .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata)
  );

  typedef struct {
    logic [31:0] addr; logic [1:0] size; logic wr; logic [31:0] wdata;
  } req_t;
  typedef struct {
    logic [31:0] addr; logic [3:0] strb; logic [31:0] data; logic wr; logic split;
  } beat_t;

  req_t  stim_q[$];
  beat_t exp_q[$];
  logic [31:0] mem [16];
  int n_tests = 0, n_fail = 0;
  logic run = 1'b0, ready_rand = 1'b0, accepted = 1'b0, rsp_flag = 1'b0;
  logic [31:0] exp_rdata = '0;
  logic exp_atomic = 1'b0, exp_wr = 1'b0;
  logic [31:0] rnd = 32'h1badf00d;
  logic prev_stall = 1'b0;
  logic [31:0] prev_addr, prev_wdata;
  logic [3:0] prev_strb;
  logic prev_wr;

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return mem[a[5:2]][8*a[1:0] +: 8];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [1:0] s, input logic w, input logic [31:0] d);
    req_t r;
    r.addr = a; r.size = s; r.wr = w; r.wdata = d;
    stim_q.push_back(r);
  endtask

  // expected beats and response from a byte-addressed view
  task automatic predict_accept(input req_t r);
    beat_t b0, b1;
    int n;
    logic two;
    n = (r.size == 2'd0) ? 1 : (r.size == 2'd1) ? 2 : 4;
    b0.addr = {r.addr[31:2], 2'b00}; b1.addr = b0.addr + 32'd4;
    b0.strb = '0; b1.strb = '0; b0.data = '0; b1.data = '0;
    b0.wr = r.wr; b1.wr = r.wr;
    two = 1'b0;
    exp_rdata = '0;
    for (int k = 0; k < n; k++) begin
      logic [31:0] a;
      a = r.addr + k;
      exp_rdata[8*k +: 8] = mbyte(a);
      if (a[31:2] != r.addr[31:2]) begin
        two = 1'b1;
        b1.strb[a[1:0]] = 1'b1;
        if (r.wr) b1.data[8*a[1:0] +: 8] = r.wdata[8*k +: 8];
      end else begin
        b0.strb[a[1:0]] = 1'b1;
        if (r.wr) b0.data[8*a[1:0] +: 8] = r.wdata[8*k +: 8];
      end
    end
    b0.split = two; b1.split = two;
    exp_q.push_back(b0);
    if (two) exp_q.push_back(b1);
    exp_atomic = !two;
    exp_wr = r.wr;
  endtask

  always @(negedge clk) if (run) begin
    logic rsp_next;
    req_t r;
    // drive
    if (accepted) begin req_valid = 1'b0; accepted = 1'b0; end
    if (!req_valid && stim_q.size() > 0) begin
      r = stim_q.pop_front();
      req_valid = 1'b1; req_addr = r.addr; req_size = r.size;
      req_write = r.wr; req_wdata = r.wdata;
    end
    rnd = xs(rnd);
    bus_ready = ready_rand ? (rnd[3:0] > 4'd4) : 1'b1;
    bus_rdata = mem[bus_addr_o[5:2]];
    // compare
    chk("R6 req_ready", {31'd0, req_ready_o}, {31'd0, (exp_q.size() == 0) && !rsp_flag});
    chk("R2 bus_valid", {31'd0, bus_valid_o}, {31'd0, exp_q.size() != 0});
    if (prev_stall) begin
      chk("R7 held addr", bus_addr_o, prev_addr);
      chk("R7 held strb", {28'd0, bus_strb_o}, {28'd0, prev_strb});
      chk("R7 held wdata", bus_wdata_o, prev_wdata);
      chk("R7 held dir", {31'd0, bus_write_o}, {31'd0, prev_wr});
    end
    if (bus_valid_o && exp_q.size() != 0) begin
      chk(exp_q[0].split ? "R2 split beat addr" : "R1 single beat addr", bus_addr_o, exp_q[0].addr);
      chk(exp_q[0].split ? "R2 split beat strb" : "R1 single beat strb",
          {28'd0, bus_strb_o}, {28'd0, exp_q[0].strb});
      chk("R3 lane data", bus_wdata_o, exp_q[0].data);
      chk("R3 direction", {31'd0, bus_write_o}, {31'd0, exp_q[0].wr});
    end
    chk("R5 rsp_valid", {31'd0, rsp_valid_o}, {31'd0, rsp_flag});
    if (rsp_flag) begin
      chk("R5 atomic flag", {31'd0, rsp_atomic_o}, {31'd0, exp_atomic});
      if (exp_wr) chk("R8 write rdata zero", rsp_rdata_o, 32'd0);
      else        chk("R4 read merge", rsp_rdata_o, exp_rdata);
    end
    prev_stall = bus_valid_o && !bus_ready;
    prev_addr = bus_addr_o; prev_strb = bus_strb_o; prev_wdata = bus_wdata_o; prev_wr = bus_write_o;
    // advance model to next edge
    rsp_next = 1'b0;
    if (bus_valid_o && bus_ready && exp_q.size() != 0) begin
      beat_t b;
      b = exp_q.pop_front();
      if (b.wr)
        for (int i = 0; i < 4; i++)
          if (b.strb[i]) mem[b.addr[5:2]][8*i +: 8] = b.data[8*i +: 8];
      if (exp_q.size() == 0) rsp_next = 1'b1;
    end
    if (req_valid && req_ready_o) begin
      r.addr = req_addr; r.size = req_size; r.wr = req_write; r.wdata = req_wdata;
      predict_accept(r);
      accepted = 1'b1;
    end
    rsp_flag = rsp_next;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic drain();
    while (!(stim_q.size() == 0 && !req_valid && exp_q.size() == 0 && !rsp_flag))
      @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h03020100 + i * 32'h04040404;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 reset req_ready", {31'd0, req_ready_o}, 32'd1);
    chk("R9 reset bus_valid", {31'd0, bus_valid_o}, 32'd0);
    chk("R9 reset rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
    rst_ni = 1'b1;
    @(posedge clk);
    run = 1'b1;
    // directed boundary cases
    push(32'h02, 2'd2, 1'b1, 32'hDDCCBBAA);  // R2 word offset 2 write
    push(32'h02, 2'd2, 1'b0, 32'h0);         // R2 R4 split read back
    push(32'h00, 2'd2, 1'b0, 32'h0);         // R1 aligned word
    push(32'h03, 2'd1, 1'b1, 32'hFFFF1234);  // R2 halfword offset 3
    push(32'h03, 2'd1, 1'b0, 32'h0);
    push(32'h01, 2'd1, 1'b0, 32'h0);         // R1 halfword offset 1, one beat
    push(32'h07, 2'd0, 1'b1, 32'hFFFFFF5A);  // R3 byte lane 3
    push(32'h07, 2'd0, 1'b0, 32'h0);
    push(32'h0D, 2'd3, 1'b0, 32'h0);         // R1 size 3 as word, split
    push(32'h0B, 2'd2, 1'b1, 32'h87654321);  // R3 offset 3 write
    push(32'h08, 2'd2, 1'b0, 32'h0);
    push(32'h0C, 2'd2, 1'b0, 32'h0);
    push(32'h22, 2'd1, 1'b1, 32'h0000BEEF);
    push(32'h21, 2'd1, 1'b0, 32'h0);
    push(32'h3F, 2'd2, 1'b0, 32'h0);         // wraps modelled space
    drain();
    ready_rand = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, d;
      a = xs(32'h9e3779b9 + i * 32'h85ebca6b);
      d = xs(a ^ 32'hc2b2ae35);
      push({26'd0, a[5:0]}, a[7:6], a[8], d);
    end
    drain();
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=%0d exp=done", 50000);
    summary();
  end
endmodule